// File: doc/BRIEF.md
# Special-Register Write Path

This block takes a 32-bit value from a general-purpose register and writes it into one of a small set of processor special registers. A 4-bit selector names the target. The targets are a status word, two stack pointers, three interrupt-mask registers and a control register. The status word has two writable fields: arithmetic flags and a SIMD greater-or-equal (GE) field.

Writes are gated by privilege. In unprivileged mode, only the status word can change, and only in the field or fields that the selector names. Every other target is silently dropped.

One selector is a raise-only alias of the base-priority mask. Through that alias the mask can only be tightened, never loosened. If the source-register index names the stack pointer or the program counter, the write is refused and an error pulse is raised.

Read-back ports show every register continuously.

Top module: `sreg_write_unit`

## Requirements
- R1: A synchronous reset clears every stored register to zero and holds `illegal_op` low.
- R2: When `priv` is high, a write updates its target on the next rising edge. Selector 4 writes the main stack pointer and selector 5 writes the process stack pointer, each with bits 1:0 forced to zero. Selector 6 (primary mask) and selector 9 (fault mask) store bit 0 of the source. Selector 10 (control) stores bits 1:0.
- R3: The status flags occupy bits 31:27 and GE occupies bits 19:16. All other status bits read zero. Selector 0 writes only the flags, selector 1 writes only GE, and selector 2 writes both. Selector 3 behaves exactly like selector 0.
- R4: When `priv` is low, writes through selectors 4 to 10 change no register.
- R5: When `priv` is low, selectors 0 to 3 still update the status word, limited to the fields each selector names.
- R6: Selector 7 loads the base-priority mask from source bits 7:0. Only bits 7:4 are implemented, so bits 3:0 always read zero.
- R7: Selector 8 (raise-only) works on the implemented value v, which is source bits 7:4 followed by four zero bits. It writes v only when v is non-zero and either the current mask is zero or v is less than the current mask. Otherwise the mask is unchanged.
- R8: A write whose `src_idx` is 13 or 15 changes no register. `illegal_op` is then high for exactly the one cycle after that edge.
- R9: Selector codes 11 to 15 change no register and raise no error.
- R10: When `wr_en` is low, no register changes and `illegal_op` is low after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| sel | input | 4 | Target selector code |
| src_idx | input | 4 | Index of the source general-purpose register |
| src_val | input | 32 | Source value |
| priv | input | 1 | High when the writer is privileged |
| illegal_op | output | 1 | One-cycle pulse for a refused source register |
| status_q | output | 32 | Status word read-back |
| main_sp_q | output | 32 | Main stack pointer read-back |
| proc_sp_q | output | 32 | Process stack pointer read-back |
| irq_mask_q | output | 1 | Primary interrupt mask read-back |
| base_prio_q | output | 8 | Base-priority mask read-back |
| fault_mask_q | output | 1 | Fault mask read-back |
| ctrl_q | output | 2 | Control register read-back |

## Verification
Every stored register drives a read-back port directly. A wrong enable, a wrong field mask or a wrong raise-only comparison therefore shows on the ports one edge after the write that caused it. The bench compares all seven read-backs and the error pulse after every write, so a write that leaks into another register is caught in the same cycle. The raise-only alias is driven with values above, equal to and below the current mask, and with a non-zero source whose implemented value is zero, so an off-by-one comparison or a truncation mistake changes a visible value.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int SEL_W   = 4;
  localparam int IDX_W   = 4;
  localparam int DATA_W  = 32;
  localparam int PRIO_W  = 8;
  localparam int FLAG_HI = 31;
  localparam int FLAG_LO = 27;
  localparam int GE_HI   = 19;
  localparam int GE_LO   = 16;
  localparam int FLAG_W  = FLAG_HI - FLAG_LO + 1;
  localparam int GE_W    = GE_HI - GE_LO + 1;
  localparam logic [IDX_W-1:0] IDX_SP = 4'd13;
  localparam logic [IDX_W-1:0] IDX_PC = 4'd15;

  typedef enum logic [SEL_W-1:0] {
    SEL_FLAGS      = 4'd0,
    SEL_GE         = 4'd1,
    SEL_FLAGS_GE   = 4'd2,
    SEL_STATUS     = 4'd3,
    SEL_MAIN_SP    = 4'd4,
    SEL_PROC_SP    = 4'd5,
    SEL_IRQ_MASK   = 4'd6,
    SEL_BASE_PRIO  = 4'd7,
    SEL_BASE_RAISE = 4'd8,
    SEL_FAULT_MASK = 4'd9,
    SEL_CTRL       = 4'd10
  } sel_e;

  typedef struct packed {
    logic flags;
    logic ge;
    logic main_sp;
    logic proc_sp;
    logic irq_mask;
    logic bprio;
    logic braise;
    logic fault_mask;
    logic ctrl;
  } wr_vec_t;

  // True when the source index names a register that may not feed a write.
  function automatic logic f_src_illegal(input logic [IDX_W-1:0] idx);
    return (idx == IDX_SP) || (idx == IDX_PC);
  endfunction

  // Keeps the upper 'bits' bits of a priority byte and clears the rest.
  function automatic logic [PRIO_W-1:0] f_prio_impl(input logic [PRIO_W-1:0] v,
                                                    input int bits);
    logic [PRIO_W-1:0] keep;
    keep = {PRIO_W{1'b1}} << (PRIO_W - bits);
    return v & keep;
  endfunction

  // Raise-only acceptance: the candidate must be non-zero and tighter than
  // the current mask, where a zero mask counts as no masking at all.
  function automatic logic f_raise_ok(input logic [PRIO_W-1:0] cur,
                                      input logic [PRIO_W-1:0] cand);
    return (cand != '0) && ((cur == '0) || (cand < cur));
  endfunction

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             priv,
  input  logic [SEL_W-1:0] sel,
  input  logic [IDX_W-1:0] src_idx,
  output wr_vec_t          we,
  output logic             bad_src,
  output logic             sel_undef
);

  logic go;
  logic go_priv;

  assign bad_src = wr_en && f_src_illegal(src_idx);
  assign go      = wr_en && !bad_src;
  assign go_priv = go && priv;

  always_comb begin
    we        = '0;
    sel_undef = 1'b0;
    case (sel)
      SEL_FLAGS, SEL_STATUS: we.flags      = go;
      SEL_GE:                we.ge         = go;
      SEL_FLAGS_GE: begin
                             we.flags      = go;
                             we.ge         = go;
      end
      SEL_MAIN_SP:           we.main_sp    = go_priv;
      SEL_PROC_SP:           we.proc_sp    = go_priv;
      SEL_IRQ_MASK:          we.irq_mask   = go_priv;
      SEL_BASE_PRIO:         we.bprio      = go_priv;
      SEL_BASE_RAISE:        we.braise     = go_priv;
      SEL_FAULT_MASK:        we.fault_mask = go_priv;
      SEL_CTRL:              we.ctrl       = go_priv;
      default:               sel_undef     = 1'b1;
    endcase
  end

  p_undef_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    sel_undef |-> (we == '0));

  p_unpriv_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !priv |-> !(we.main_sp || we.proc_sp || we.irq_mask || we.bprio ||
                we.braise || we.fault_mask || we.ctrl));

  p_bad_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    bad_src |-> (we == '0));

endmodule

// File: rtl/sreg_field.sv
module sreg_field #(
  parameter int           W    = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)     q_r <= '0;
    else if (we) q_r <= d & KEEP;
  end

  assign q = q_r;

  p_field_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/sreg_status.sv
module sreg_status
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we_flags,
  input  logic              we_ge,
  input  logic [FLAG_W-1:0] flag_src,
  input  logic [GE_W-1:0]   ge_src,
  output logic [DATA_W-1:0] status_q
);

  logic [FLAG_W-1:0] flags_r;
  logic [GE_W-1:0]   ge_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_r <= '0;
      ge_r    <= '0;
    end else begin
      if (we_flags) flags_r <= flag_src;
      if (we_ge)    ge_r    <= ge_src;
    end
  end

  always_comb begin
    status_q                = '0;
    status_q[FLAG_HI:FLAG_LO] = flags_r;
    status_q[GE_HI:GE_LO]     = ge_r;
  end

  p_flag_load_r3: assert property (@(posedge clk) disable iff (rst)
    we_flags |=> (status_q[FLAG_HI:FLAG_LO] == $past(flag_src)));

  p_ge_load_r3: assert property (@(posedge clk) disable iff (rst)
    we_ge |=> (status_q[GE_HI:GE_LO] == $past(ge_src)));

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !we_flags |=> $stable(status_q[FLAG_HI:FLAG_LO]));

  p_ge_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !we_ge |=> $stable(status_q[GE_HI:GE_LO]));

endmodule

// File: rtl/sreg_bprio.sv
module sreg_bprio
  import sreg_pkg::*;
#(
  parameter int PRIO_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_plain,
  input  logic              we_raise,
  input  logic [PRIO_W-1:0] src8,
  output logic [PRIO_W-1:0] bprio_q
);

  localparam int LO = PRIO_W - PRIO_BITS;

  logic [PRIO_W-1:0] bprio_r;
  logic [PRIO_W-1:0] cand;
  logic              raise_take;
  logic              take;

  assign cand       = f_prio_impl(src8, PRIO_BITS);
  assign raise_take = we_raise && f_raise_ok(bprio_r, cand);
  assign take       = we_plain || raise_take;

  always_ff @(posedge clk) begin
    if (rst)       bprio_r <= '0;
    else if (take) bprio_r <= cand;
  end

  assign bprio_q = bprio_r;

  p_plain_load_r6: assert property (@(posedge clk) disable iff (rst)
    we_plain |=> (bprio_q[PRIO_W-1:LO] == $past(src8[PRIO_W-1:LO])));

  p_raise_only_r7: assert property (@(posedge clk) disable iff (rst)
    we_raise |=> ((bprio_q == $past(bprio_q)) ||
                  ((bprio_q != '0) &&
                   (($past(bprio_q) == '0) || (bprio_q < $past(bprio_q))))));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(we_plain || we_raise) |=> $stable(bprio_q));

endmodule

// File: rtl/sreg_write_unit.sv
module sreg_write_unit
  import sreg_pkg::*;
#(
  parameter int PRIO_BITS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  sel,
  input  logic [3:0]  src_idx,
  input  logic [31:0] src_val,
  input  logic        priv,
  output logic        illegal_op,
  output logic [31:0] status_q,
  output logic [31:0] main_sp_q,
  output logic [31:0] proc_sp_q,
  output logic        irq_mask_q,
  output logic [7:0]  base_prio_q,
  output logic        fault_mask_q,
  output logic [1:0]  ctrl_q
);

  localparam int          NUM_SP  = 2;
  localparam logic [31:0] SP_KEEP = 32'hFFFF_FFFC;

  wr_vec_t     we;
  logic        bad_src;
  logic        sel_undef;
  logic        illegal_r;
  logic [31:0] sp_q  [NUM_SP];
  logic        sp_we [NUM_SP];

  sreg_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .priv      (priv),
    .sel       (sel),
    .src_idx   (src_idx),
    .we        (we),
    .bad_src   (bad_src),
    .sel_undef (sel_undef)
  );

  sreg_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .we_flags (we.flags),
    .we_ge    (we.ge),
    .flag_src (src_val[FLAG_HI:FLAG_LO]),
    .ge_src   (src_val[GE_HI:GE_LO]),
    .status_q (status_q)
  );

  assign sp_we[0] = we.main_sp;
  assign sp_we[1] = we.proc_sp;

  for (genvar g = 0; g < NUM_SP; g++) begin : g_sp
    sreg_field #(.W(32), .KEEP(SP_KEEP)) u_sp (
      .clk (clk),
      .rst (rst),
      .we  (sp_we[g]),
      .d   (src_val),
      .q   (sp_q[g])
    );
  end

  assign main_sp_q = sp_q[0];
  assign proc_sp_q = sp_q[1];

  sreg_field #(.W(1)) u_irqm (
    .clk (clk), .rst (rst), .we (we.irq_mask), .d (src_val[0]), .q (irq_mask_q)
  );

  sreg_field #(.W(1)) u_fltm (
    .clk (clk), .rst (rst), .we (we.fault_mask), .d (src_val[0]), .q (fault_mask_q)
  );

  sreg_field #(.W(2)) u_ctrl (
    .clk (clk), .rst (rst), .we (we.ctrl), .d (src_val[1:0]), .q (ctrl_q)
  );

  sreg_bprio #(.PRIO_BITS(PRIO_BITS)) u_bp (
    .clk      (clk),
    .rst      (rst),
    .we_plain (we.bprio),
    .we_raise (we.braise),
    .src8     (src_val[7:0]),
    .bprio_q  (base_prio_q)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal_r <= 1'b0;
    else     illegal_r <= bad_src;
  end

  assign illegal_op = illegal_r;

  p_bad_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    bad_src |=> illegal_op);

  p_bad_nochange_r8: assert property (@(posedge clk) disable iff (rst)
    bad_src |=> $stable({status_q, main_sp_q, proc_sp_q, irq_mask_q,
                         base_prio_q, fault_mask_q, ctrl_q}));

  p_undef_nochange_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_undef) |=> ($stable({status_q, main_sp_q, proc_sp_q, irq_mask_q,
                                      base_prio_q, fault_mask_q, ctrl_q}) &&
                             (illegal_op == $past(bad_src))));

  p_no_err_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !illegal_op);

  p_unpriv_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !priv) |=> $stable({main_sp_q, proc_sp_q, irq_mask_q,
                                  base_prio_q, fault_mask_q, ctrl_q}));

endmodule

// File: tb/sim_sreg_write_unit.sv
`timescale 1ns/1ps
module sim_sreg_write_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  sel;
  logic [3:0]  src_idx;
  logic [31:0] src_val;
  logic        priv;
  logic        illegal_op;
  logic [31:0] status_q, main_sp_q, proc_sp_q;
  logic        irq_mask_q, fault_mask_q;
  logic [7:0]  base_prio_q;
  logic [1:0]  ctrl_q;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // expected state, maintained by each scenario from the requirements
  logic [31:0] e_stat, e_msp, e_psp;
  logic        e_pm, e_fm, e_err;
  logic [7:0]  e_bp;
  logic [1:0]  e_ctrl;

  always #5 clk = ~clk;

  sreg_write_unit u0 (
    .clk (clk), .rst (rst), .wr_en (wr_en), .sel (sel), .src_idx (src_idx),
    .src_val (src_val), .priv (priv), .illegal_op (illegal_op),
    .status_q (status_q), .main_sp_q (main_sp_q), .proc_sp_q (proc_sp_q),
    .irq_mask_q (irq_mask_q), .base_prio_q (base_prio_q),
    .fault_mask_q (fault_mask_q), .ctrl_q (ctrl_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "status",     status_q,            e_stat);
    chk(req, "main_sp",    main_sp_q,           e_msp);
    chk(req, "proc_sp",    proc_sp_q,           e_psp);
    chk(req, "irq_mask",   {31'd0, irq_mask_q}, {31'd0, e_pm});
    chk(req, "fault_mask", {31'd0, fault_mask_q}, {31'd0, e_fm});
    chk(req, "base_prio",  {24'd0, base_prio_q}, {24'd0, e_bp});
    chk(req, "ctrl",       {30'd0, ctrl_q},     {30'd0, e_ctrl});
    chk(req, "illegal_op", {31'd0, illegal_op}, {31'd0, e_err});
  endtask

  // one write cycle: drive at a falling edge, strobe removed at the next
  // falling edge, by which point the rising edge in between has acted
  task automatic wr(input logic [3:0] s, input logic [31:0] v,
                    input logic p, input logic [3:0] idx);
    @(negedge clk);
    wr_en = 1'b1; sel = s; src_val = v; priv = p; src_idx = idx;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_r1();
    rst = 1'b1; wr_en = 1'b0; sel = '0; src_idx = 4'd1; src_val = '0; priv = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    e_stat = '0; e_msp = '0; e_psp = '0; e_pm = 0; e_fm = 0; e_bp = '0;
    e_ctrl = '0; e_err = 0;
    check_all("R1");
  endtask

  task automatic t_priv_r2();
    wr(4'd4, 32'h2000_1237, 1, 4'd1); e_msp = 32'h2000_1234; check_all("R2");
    wr(4'd5, 32'hFFFF_FFFF, 1, 4'd2); e_psp = 32'hFFFF_FFFC; check_all("R2");
    wr(4'd6, 32'hFFFF_FFFE, 1, 4'd3); e_pm = 0;              check_all("R2");
    wr(4'd6, 32'h0000_0003, 1, 4'd3); e_pm = 1;              check_all("R2");
    wr(4'd9, 32'h0000_0001, 1, 4'd0); e_fm = 1;              check_all("R2");
    wr(4'd10, 32'hFFFF_FFFF, 1, 4'd14); e_ctrl = 2'b11;      check_all("R2");
  endtask

  task automatic t_status_r3();
    wr(4'd0, 32'hFFFF_FFFF, 1, 4'd1); e_stat = 32'hF800_0000; check_all("R3");
    wr(4'd1, 32'h000A_0000, 1, 4'd1); e_stat = 32'hF80A_0000; check_all("R3");
    wr(4'd2, 32'h5005_0000, 1, 4'd1); e_stat = 32'h5005_0000; check_all("R3");
    wr(4'd3, 32'h80FF_FFFF, 1, 4'd1); e_stat = 32'h8005_0000; check_all("R3");
  endtask

  task automatic t_unpriv_block_r4();
    wr(4'd4, 32'h1111_1110, 0, 4'd1); check_all("R4");
    wr(4'd5, 32'h0000_0000, 0, 4'd1); check_all("R4");
    wr(4'd6, 32'h0000_0000, 0, 4'd1); check_all("R4");
    wr(4'd7, 32'h0000_00F0, 0, 4'd1); check_all("R4");
    wr(4'd8, 32'h0000_0010, 0, 4'd1); check_all("R4");
    wr(4'd9, 32'h0000_0000, 0, 4'd1); check_all("R4");
    wr(4'd10, 32'h0000_0000, 0, 4'd1); check_all("R4");
  endtask

  task automatic t_unpriv_status_r5();
    wr(4'd2, 32'hFFFF_FFFF, 0, 4'd1); e_stat = 32'hF80F_0000; check_all("R5");
    wr(4'd1, 32'h0000_0000, 0, 4'd1); e_stat = 32'hF800_0000; check_all("R5");
    wr(4'd0, 32'h0FFF_FFFF, 0, 4'd1); e_stat = 32'h0800_0000; check_all("R5");
  endtask

  task automatic t_bprio_r6();
    wr(4'd7, 32'h1234_56A7, 1, 4'd1); e_bp = 8'hA0; check_all("R6");
  endtask

  task automatic t_raise_r7();
    wr(4'd8, 32'h0000_00C0, 1, 4'd1);                check_all("R7"); // looser
    wr(4'd8, 32'h0000_00A5, 1, 4'd1);                check_all("R7"); // equal
    wr(4'd8, 32'h0000_0060, 1, 4'd1); e_bp = 8'h60;  check_all("R7"); // tighter
    wr(4'd8, 32'h0000_006F, 1, 4'd1);                check_all("R7"); // equal impl
    wr(4'd8, 32'h0000_000F, 1, 4'd1);                check_all("R7"); // impl zero
    wr(4'd8, 32'h0000_0000, 1, 4'd1);                check_all("R7"); // zero
    wr(4'd7, 32'h0000_0000, 1, 4'd1); e_bp = 8'h00;  check_all("R6");
    wr(4'd8, 32'h0000_000F, 1, 4'd1);                check_all("R7");
    wr(4'd8, 32'h0000_00F3, 1, 4'd1); e_bp = 8'hF0;  check_all("R7"); // from zero
  endtask

  task automatic t_bad_src_r8();
    wr(4'd4, 32'h0000_0100, 1, 4'd13); e_err = 1; check_all("R8");
    @(negedge clk);                    e_err = 0; check_all("R8");
    wr(4'd2, 32'hFFFF_FFFF, 1, 4'd15); e_err = 1; check_all("R8");
    wr(4'd9, 32'h0000_0000, 1, 4'd14); e_err = 0; e_fm = 0; check_all("R8");
  endtask

  task automatic t_undef_r9();
    for (int s = 11; s < 16; s++) begin
      wr(4'(s), 32'hFFFF_FFFF, 1, 4'd1);
      check_all("R9");
    end
  endtask

  task automatic t_no_strobe_r10();
    @(negedge clk);
    wr_en = 1'b0; sel = 4'd4; src_val = 32'hDEAD_BEE0; priv = 1; src_idx = 4'd13;
    repeat (2) @(negedge clk);
    check_all("R10");
    sel = 4'd2;
    @(negedge clk);
    check_all("R10");
  endtask

  initial begin
    t_reset_r1();
    t_priv_r2();
    t_status_r3();
    t_unpriv_block_r4();
    t_unpriv_status_r5();
    t_bprio_r6();
    t_raise_r7();
    t_bad_src_r8();
    t_undef_r9();
    t_no_strobe_r10();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule